// File: doc/BRIEF.md
# Flash Identification-Mode Command Front End

This block models, cycle by cycle, the command front end of a banked NOR flash for its identification mode. It watches the bus write channel for a three-write unlock-and-identify sequence. It first checks that no embedded program or erase is running. It then switches one bank into identification mode. While the mode is active, reads that land in that bank at a small set of offsets return codes from an internal table instead of array data. The codes are a manufacturer code, a device code picked by a build parameter, the protection flag of the addressed block, and a flag for the handshaking configuration. All other reads pass the array data through unchanged.

Reads use a valid/ready request channel and a valid/ready response channel. The response register is one entry deep. A request is accepted only when the response register is empty or is being drained in the same cycle, so `req_ready = !rsp_valid || rsp_ready`. A response that has not been taken stays unchanged. Writes are plain strobes and are never stalled. A write whose low byte is F0h leaves the mode and also cancels a partly entered sequence.

Top module: `flash_idmode_ctrl`

## Requirements
- R1: After reset, `id_active` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Three writes enter the mode: cmd AAh with address low 12 bits 555h, then 55h at 2AAh, then 90h at 555h. `id_active` is 1 from the clock edge after the third write. `id_bank` then holds the top two address bits of the third write.
- R3: A wrong command byte or a wrong address at any step returns the decoder to idle without entering the mode. A new sequence must start again from the first write.
- R4: If `busy` is 1 during the third write, entry is refused and `id_active` stays 0.
- R5: In the mode, a read in the active bank at in-block offset 0 (address bits [15:0]) returns 00ECh.
- R6: Offset 1 returns the device code set by `DEV_CFG`: 0 gives 2206h, 1 gives 2207h, 2 gives 301Bh.
- R7: Offset 2 returns 0001h if `blk_protect[addr[19:16]]` is 1, and 0000h if it is 0.
- R8: Offset 3 returns 0000h when `HANDSHAKE` is 1 and 0001h when it is 0.
- R9: A read outside the active bank, at an offset of 4 or more, or while the mode is inactive returns `array_data` as sampled at acceptance.
- R10: Any number of identification reads, in any block of the active bank, may follow a single entry.
- R11: A write whose low byte is F0h clears `id_active` at the next edge and cancels any partial sequence.
- R12: A request with `req_burst` = 1 while the mode is active responds with `rsp_err` = 1 and data 0. Outside the mode, a burst request passes the array data with `rsp_err` = 0.
- R13: A request is accepted when `req_valid && req_ready`, and its response appears at the next edge. While `rsp_valid && !rsp_ready`, `req_ready` is 0 and the response stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_cmd | input | 8 | Write data low byte (command) |
| busy | input | 1 | Embedded program/erase in progress |
| blk_protect | input | 2**BLK_W | Per-block protection flags |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted |
| req_addr | input | ADDR_W | Read address |
| req_burst | input | 1 | Request is a burst read |
| array_data | input | DATA_W | Array read data for `req_addr` |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Response data |
| rsp_err | output | 1 | Burst refused in identification mode |
| id_active | output | 1 | Identification mode active |
| id_bank | output | BANK_W | Bank in identification mode |

## Verification
A sequence decoder stuck in the wrong step shows up on `id_active` at the edge after the third write. It may rise after a corrupted sequence, or fail to rise after a clean one. A wrong bank latch or a wrong offset decode shows up on the first response after acceptance: an identification code appears where array data was due, or the reverse. A broken hold path in the response register changes `rsp_data` during a stall cycle, so it is visible one edge after `rsp_ready` drops.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_UNL1, SEQ_UNL2} seq_state_t;

  localparam logic [11:0] UNL_ADDR_A = 12'h555;
  localparam logic [11:0] UNL_ADDR_B = 12'h2AA;
  localparam logic [7:0]  CMD_UNL_A  = 8'hAA;
  localparam logic [7:0]  CMD_UNL_B  = 8'h55;
  localparam logic [7:0]  CMD_IDENT  = 8'h90;
  localparam logic [7:0]  CMD_EXIT   = 8'hF0;

  localparam logic [15:0] MFR_CODE   = 16'h00EC;
  localparam logic [15:0] DEV_TOP    = 16'h2206;
  localparam logic [15:0] DEV_BOTTOM = 16'h2207;
  localparam logic [15:0] DEV_UNIF   = 16'h301B;

  localparam int unsigned ID_OFS_COUNT = 4;
endpackage

// File: rtl/fid_cmd_decoder.sv
module fid_cmd_decoder
  import flash_id_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_cmd,
  input  logic              busy,
  output logic              id_active,
  output logic [BANK_W-1:0] id_bank
);
  localparam int unsigned LO_W = 12;

  seq_state_t        state_q, state_d;
  logic              active_d;
  logic [BANK_W-1:0] bank_d;
  logic [LO_W-1:0]   lo_addr;
  logic              unused_mid_bits;

  assign lo_addr         = wr_addr[LO_W-1:0];
  assign unused_mid_bits = ^wr_addr[ADDR_W-BANK_W-1:LO_W];

  always_comb begin
    state_d  = state_q;
    active_d = id_active;
    bank_d   = id_bank;
    if (wr_en) begin
      if (wr_cmd == CMD_EXIT) begin
        state_d  = SEQ_IDLE;
        active_d = 1'b0;
      end else begin
        unique case (state_q)
          SEQ_IDLE: state_d = (wr_cmd == CMD_UNL_A && lo_addr == UNL_ADDR_A) ? SEQ_UNL1 : SEQ_IDLE;
          SEQ_UNL1: state_d = (wr_cmd == CMD_UNL_B && lo_addr == UNL_ADDR_B) ? SEQ_UNL2 : SEQ_IDLE;
          SEQ_UNL2: begin
            state_d = SEQ_IDLE;
            if (wr_cmd == CMD_IDENT && lo_addr == UNL_ADDR_A && !busy) begin
              active_d = 1'b1;
              bank_d   = wr_addr[ADDR_W-1 -: BANK_W];
            end
          end
          default: state_d = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      id_active <= 1'b0;
      id_bank   <= '0;
    end else begin
      state_q   <= state_d;
      id_active <= active_d;
      id_bank   <= bank_d;
    end
  end

  AST_ENTRY_NEEDS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_active) |-> $past(wr_en && wr_cmd == CMD_IDENT && !busy)); // R2
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !id_active) |=> !id_active); // R4
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd == CMD_EXIT) |=> !id_active); // R11
endmodule

// File: rtl/fid_id_lookup.sv
module fid_id_lookup
  import flash_id_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned DEV_CFG   = 0,
  parameter bit          HANDSHAKE = 1'b1
) (
  input  logic                  id_active,
  input  logic [BANK_W-1:0]     id_bank,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [(1<<BLK_W)-1:0] blk_protect,
  output logic                  hit,
  output logic [DATA_W-1:0]     id_data
);
  localparam int unsigned OFS_W = ADDR_W - BLK_W;

  logic [BANK_W-1:0] rd_bank;
  logic [BLK_W-1:0]  rd_blk;
  logic [OFS_W-1:0]  rd_ofs;
  logic [15:0]       dev_word;
  logic [15:0]       hs_word;

  assign rd_bank = rd_addr[ADDR_W-1 -: BANK_W];
  assign rd_blk  = rd_addr[ADDR_W-1 -: BLK_W];
  assign rd_ofs  = rd_addr[OFS_W-1:0];

  generate
    if (DEV_CFG == 1) begin : g_bottom
      assign dev_word = DEV_BOTTOM;
    end else if (DEV_CFG == 2) begin : g_unif
      assign dev_word = DEV_UNIF;
    end else begin : g_top
      assign dev_word = DEV_TOP;
    end
    if (HANDSHAKE) begin : g_hs
      assign hs_word = 16'h0000;
    end else begin : g_nohs
      assign hs_word = 16'h0001;
    end
  endgenerate

  assign hit = id_active && (rd_bank == id_bank) && (rd_ofs < OFS_W'(ID_OFS_COUNT));

  always_comb begin
    unique case (rd_ofs[1:0])
      2'd0:    id_data = DATA_W'(MFR_CODE);
      2'd1:    id_data = DATA_W'(dev_word);
      2'd2:    id_data = DATA_W'(blk_protect[rd_blk]);
      default: id_data = DATA_W'(hs_word);
    endcase
  end
endmodule

// File: rtl/fid_read_port.sv
module fid_read_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_burst,
  input  logic              id_active,
  input  logic              hit,
  input  logic [DATA_W-1:0] id_data,
  input  logic [DATA_W-1:0] array_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      if (id_active && req_burst) begin
        rsp_data <= '0;
        rsp_err  <= 1'b1;
      end else if (hit) begin
        rsp_data <= id_data;
        rsp_err  <= 1'b0;
      end else begin
        rsp_data <= array_data;
        rsp_err  <= 1'b0;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R13
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R13
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0)); // R12
endmodule

// File: rtl/flash_idmode_ctrl.sv
module flash_idmode_ctrl #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned DEV_CFG   = 0,
  parameter bit          HANDSHAKE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_cmd,
  input  logic                  busy,
  input  logic [(1<<BLK_W)-1:0] blk_protect,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_burst,
  input  logic [DATA_W-1:0]     array_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  rsp_err,
  output logic                  id_active,
  output logic [BANK_W-1:0]     id_bank
);
  logic              hit;
  logic [DATA_W-1:0] id_data;

  fid_cmd_decoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_cmd(wr_cmd),
    .busy(busy), .id_active(id_active), .id_bank(id_bank)
  );

  fid_id_lookup #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .BLK_W(BLK_W),
    .DEV_CFG(DEV_CFG), .HANDSHAKE(HANDSHAKE)
  ) u_lut (
    .id_active(id_active), .id_bank(id_bank), .rd_addr(req_addr),
    .blk_protect(blk_protect), .hit(hit), .id_data(id_data)
  );

  fid_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_burst(req_burst), .id_active(id_active), .hit(hit), .id_data(id_data),
    .array_data(array_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_active && !wr_en) |=> $stable(id_bank)); // R10
endmodule

// File: tb/flash_idmode_ctrl_bench.sv
module flash_idmode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_cmd = '0;
  logic        busy = 1'b0;
  logic [15:0] blk_protect = 16'hA5A5;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_burst = 1'b0;
  logic [15:0] array_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        rsp_err;
  logic        id_active;
  logic [1:0]  id_bank;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign array_data = req_addr[15:0] ^ 16'h5A5A;

  flash_idmode_ctrl u_flash_idmode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_cmd(wr_cmd),
    .busy(busy), .blk_protect(blk_protect), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_burst(req_burst), .array_data(array_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .id_active(id_active), .id_bank(id_bank)
  );

  localparam int NV = 8;
  localparam logic [19:0] VADDR [NV] = '{20'h40000, 20'h40001, 20'h50002, 20'h60002,
                                          20'h40003, 20'h40004, 20'h00000, 20'h70000};
  localparam logic [15:0] VEXP  [NV] = '{16'h00EC, 16'h2206, 16'h0001, 16'h0000,
                                          16'h0000, 16'h5A5E, 16'h5A5A, 16'h00EC};
  string vtag [NV];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_cmd = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic b,
                    output logic [15:0] d, output logic e, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_burst = b; rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    d = rsp_data; e = rsp_err; v = rsp_valid;
    @(negedge clk);
    req_valid = 1'b0; req_burst = 1'b0;
  endtask

  task automatic enter(input logic [19:0] a3);
    wr(20'h00555, 8'hAA);
    wr(20'h002AA, 8'h55);
    wr(a3, 8'h90);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic e, v;
    vtag = '{"R5", "R6", "R7", "R7", "R8", "R9", "R9", "R10"};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 id_active", id_active, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    rd(20'h40000, 1'b0, d, e, v);
    chk("R9 inactive read", d, 16'h5A5A);

    enter(20'h40555);
    chk("R2 id_active", id_active, 1);
    chk("R2 id_bank", id_bank, 1);

    for (int i = 0; i < NV; i++) begin
      rd(VADDR[i], 1'b0, d, e, v);
      chk({vtag[i], " data"}, d, VEXP[i]);
      chk({vtag[i], " valid"}, v, 1);
    end
    rd(20'h7FF00, 1'b0, d, e, v);
    chk("R9 offset beyond table", d, 16'hA55A);
    rd(20'h80000, 1'b0, d, e, v);
    chk("R9 other bank", d, 16'h5A5A);

    rd(20'h40000, 1'b1, d, e, v);
    chk("R12 burst err", e, 1);
    chk("R12 burst data", d, 16'h0000);

    // R13 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 20'h40000;
    @(posedge clk); #1;
    chk("R13 valid", rsp_valid, 1);
    chk("R13 ready low", req_ready, 0);
    @(negedge clk);
    req_addr = 20'h40001;
    @(posedge clk); #1;
    chk("R13 held data", rsp_data, 16'h00EC);
    chk("R13 held valid", rsp_valid, 1);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R13 next accepted", rsp_data, 16'h2206);
    @(negedge clk);
    req_valid = 1'b0;

    wr(20'h00000, 8'hF0);
    chk("R11 exit", id_active, 0);
    rd(20'h40000, 1'b0, d, e, v);
    chk("R11 array after exit", d, 16'h5A5A);
    rd(20'h40000, 1'b1, d, e, v);
    chk("R12 burst outside err", e, 0);
    chk("R12 burst outside data", d, 16'h5A5A);

    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h56); wr(20'h40555, 8'h90);
    chk("R3 bad data", id_active, 0);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h40556, 8'h90);
    chk("R3 bad address", id_active, 0);
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55); wr(20'h002AA, 8'h55); wr(20'h40555, 8'h90);
    chk("R3 restart needed", id_active, 0);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00000, 8'hF0); wr(20'h40555, 8'h90);
    chk("R11 cancel partial", id_active, 0);

    @(negedge clk); busy = 1'b1;
    enter(20'h40555);
    chk("R4 busy refused", id_active, 0);
    @(negedge clk); busy = 1'b0;
    enter(20'hC0555);
    chk("R2 bank3 entry", id_bank, 3);
    rd(20'hC0003, 1'b0, d, e, v);
    chk("R8 bank3 handshake", d, 16'h0000);
    rd(20'h40000, 1'b0, d, e, v);
    chk("R9 old bank now array", d, 16'h5A5A);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule